// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block receives configuration writes over three slow lines: a serial data line, a serial clock line and a latch line. All three lines, and the active-low select input, come from outside the system clock domain. Each one is first synchronised into the system clock. The port then detects rising edges of the serial clock and of the latch line. It shifts one data bit on each serial clock edge. On a latch edge it commits the collected command word into one of five small control registers.

A command word is 16 bits long and arrives most significant bit first. The top four bits are ignored. A 3-bit field selects the register and a 9-bit field carries its contents. Four registers can always be written. The fifth register stays locked until a key value has been written into otherwise unused bits of the mode register. It locks again when a later mode write drops the key.

A write is discarded in any of these cases: the select line is high at commit, the ready input is low, the bit count is not exactly 16, or the address is not one of the five defined ones. There is no read path. Every register field drives its own output.

Top module: `ctl_port_top`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock line, most significant bit first, and the word is committed on the rising edge of the latch line.
- R2: Command bits 15:12 are ignored, bits 11:9 form the register address and bits 8:0 form the register data.
- R3: Address 000 sets the left level (data bits 7:0) and the left load flag (data bit 8); address 001 does the same for the right level and right load flag.
- R4: Address 010 sets word length (data bits 4:3), force-zero (bit 2), de-emphasis enable (bit 1) and soft mute (bit 0).
- R5: Address 011 sets zero-detect enable (bit 8), rate select (bits 7:6), phase reverse (bit 4), slow roll-off (bit 3), common level (bit 2), channel-select polarity (bit 1) and the I2S format flag (bit 0); data bit 5 has no effect.
- R6: Address 110 sets clock-detector disable (bit 6) and differential mode (bits 5:4). It accepts a write only while the most recent accepted address-010 write had data bits 8:5 equal to 1111, so a later 010 write without that key locks it again.
- R7: After reset both level fields read 0xFF and every other field reads 0.
- R8: A commit is ignored when the select input is high at the latch edge.
- R9: A commit is ignored while the ready input is low.
- R10: Commits to addresses 100, 101 and 111 change no output.
- R11: A commit after any number of serial clock edges other than 16 since the previous latch edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_ready_i | input | 1 | High when writes may be accepted |
| cs_n_i | input | 1 | Active-low write select |
| cfg_dat_i | input | 1 | Serial command data |
| cfg_clk_i | input | 1 | Serial command clock |
| cfg_lat_i | input | 1 | Latch line, commit on rising edge |
| att_left_o | output | 8 | Left level code |
| att_left_load_o | output | 1 | Left load flag |
| att_right_o | output | 8 | Right level code |
| att_right_load_o | output | 1 | Right load flag |
| word_len_o | output | 2 | Word length select |
| dac_force_zero_o | output | 1 | Force output to zero |
| deemph_en_o | output | 1 | De-emphasis enable |
| soft_mute_o | output | 1 | Soft mute |
| zero_det_en_o | output | 1 | Zero-detect enable |
| fs_sel_o | output | 2 | Rate select |
| phase_rev_o | output | 1 | Output phase reverse |
| slow_rolloff_o | output | 1 | Slow roll-off select |
| att_common_o | output | 1 | Use left level for both channels |
| lr_swap_o | output | 1 | Channel-select polarity |
| i2s_fmt_o | output | 1 | I2S format flag |
| clkdet_off_o | output | 1 | Clock-loss detector disable |
| diff_mode_o | output | 2 | Differential output mode |

## Verification
Most internal faults show up at the register outputs a few system clocks after the latch edge that should, or should not, have changed them.
- A shift register or bit counter that is out of step makes the wrong field move, or makes a discarded write land.
- A stale lock flag only shows later, on the next write to the hidden register.

For that reason, the key tests write the hidden register both before and after every change to the mode register.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 9;
    localparam int SYNC_STAGES = 2;
    localparam int KEY_LSB = 5;
    localparam int KEY_W   = 4;
    localparam logic [KEY_W-1:0] KEY_VAL = 4'hF;

    localparam logic [ADDR_W-1:0] ADR_LEFT  = 3'b000;
    localparam logic [ADDR_W-1:0] ADR_RIGHT = 3'b001;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 3'b010;
    localparam logic [ADDR_W-1:0] ADR_FMT   = 3'b011;
    localparam logic [ADDR_W-1:0] ADR_HID   = 3'b110;

    typedef struct packed {
        logic       ld_l;
        logic [7:0] att_l;
        logic       ld_r;
        logic [7:0] att_r;
        logic [1:0] wlen;
        logic       dac_off;
        logic       deemph;
        logic       mute;
        logic       zdet;
        logic [1:0] fs_sel;
        logic       rev;
        logic       slow;
        logic       att_com;
        logic       lrpol;
        logic       i2s;
        logic       cdo;
        logic [1:0] diff;
        logic       unlock;
    } ctl_regs_t;

    localparam ctl_regs_t REGS_RESET = '{
        ld_l: 1'b0, att_l: 8'hFF, ld_r: 1'b0, att_r: 8'hFF,
        wlen: 2'b00, dac_off: 1'b0, deemph: 1'b0, mute: 1'b0,
        zdet: 1'b0, fs_sel: 2'b00, rev: 1'b0, slow: 1'b0,
        att_com: 1'b0, lrpol: 1'b0, i2s: 1'b0,
        cdo: 1'b0, diff: 2'b00, unlock: 1'b0
    };
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int N      = 4,
    parameter int STAGES = ctl_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    logic [STAGES-1:0][N-1:0] pipe_d, pipe_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb pipe_d = {pipe_q[STAGES-2:0], async_i};
        end else begin : g_single
            always_comb pipe_d = async_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ctl_edge.sv
module ctl_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
    parameter int WORD_W = ctl_pkg::WORD_W,
    parameter int KEEP_W = ctl_pkg::ADDR_W + ctl_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              lat_stb_i,
    input  logic              sdat_i,
    output logic [KEEP_W-1:0] word_o,
    output logic              word_ok_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

    typedef struct packed {
        logic [KEEP_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lat_stb_i) begin
            st_d.cnt = '0;
        end else if (bit_stb_i) begin
            st_d.sh = {st_q.sh[KEEP_W-2:0], sdat_i};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o    = st_q.sh;
    assign word_ok_o = (st_q.cnt == CNT_WORD);

    // R1: newest serial bit enters at the bottom of the shift register
    p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_i && !lat_stb_i) |=> (st_q.sh[0] == $past(sdat_i)));

    // R11: every latch edge restarts the bit count
    p_count_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lat_stb_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import ctl_pkg::*;
#(
    parameter int AW = ctl_pkg::ADDR_W,
    parameter int DW = ctl_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic             word_ok_i,
    input  logic [AW+DW-1:0] word_i,
    input  logic             cs_n_i,
    input  logic             ready_i,
    output ctl_regs_t        regs_o
);
    ctl_regs_t regs_d, regs_q;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          accept;

    always_comb begin
        wr_addr = word_i[DW +: AW];
        wr_data = word_i[DW-1:0];
        accept  = wr_stb_i && word_ok_i && !cs_n_i && ready_i;
        regs_d  = regs_q;
        if (accept) begin
            case (wr_addr)
                ADR_LEFT: begin
                    regs_d.ld_l  = wr_data[8];
                    regs_d.att_l = wr_data[7:0];
                end
                ADR_RIGHT: begin
                    regs_d.ld_r  = wr_data[8];
                    regs_d.att_r = wr_data[7:0];
                end
                ADR_MODE: begin
                    regs_d.wlen    = wr_data[4:3];
                    regs_d.dac_off = wr_data[2];
                    regs_d.deemph  = wr_data[1];
                    regs_d.mute    = wr_data[0];
                    regs_d.unlock  = (wr_data[KEY_LSB +: KEY_W] == KEY_VAL);
                end
                ADR_FMT: begin
                    regs_d.zdet    = wr_data[8];
                    regs_d.fs_sel  = wr_data[7:6];
                    regs_d.rev     = wr_data[4];
                    regs_d.slow    = wr_data[3];
                    regs_d.att_com = wr_data[2];
                    regs_d.lrpol   = wr_data[1];
                    regs_d.i2s     = wr_data[0];
                end
                ADR_HID: begin
                    if (regs_q.unlock) begin
                        regs_d.cdo  = wr_data[6];
                        regs_d.diff = wr_data[5:4];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    // R6: locked hidden register holds its value
    p_hidden_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == ADR_HID && !regs_q.unlock)
        |=> ($stable(regs_q.cdo) && $stable(regs_q.diff)));

    // R6: a mode write without the key re-locks
    p_key_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_addr == ADR_MODE && wr_data[KEY_LSB +: KEY_W] != KEY_VAL)
        |=> !regs_q.unlock);

    // R8: select high blocks the commit
    p_cs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && cs_n_i) |=> $stable(regs_q));

    // R9: not ready blocks the commit
    p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(regs_q));

    // R10: undefined addresses change nothing
    p_undef_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && (wr_addr == 3'b100 || wr_addr == 3'b101 || wr_addr == 3'b111))
        |=> $stable(regs_q));

    // R11: wrong bit count changes nothing
    p_len_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !word_ok_i) |=> $stable(regs_q));
endmodule

// File: rtl/ctl_port_top.sv
module ctl_port_top
    import ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_ready_i,
    input  logic       cs_n_i,
    input  logic       cfg_dat_i,
    input  logic       cfg_clk_i,
    input  logic       cfg_lat_i,
    output logic [7:0] att_left_o,
    output logic       att_left_load_o,
    output logic [7:0] att_right_o,
    output logic       att_right_load_o,
    output logic [1:0] word_len_o,
    output logic       dac_force_zero_o,
    output logic       deemph_en_o,
    output logic       soft_mute_o,
    output logic       zero_det_en_o,
    output logic [1:0] fs_sel_o,
    output logic       phase_rev_o,
    output logic       slow_rolloff_o,
    output logic       att_common_o,
    output logic       lr_swap_o,
    output logic       i2s_fmt_o,
    output logic       clkdet_off_o,
    output logic [1:0] diff_mode_o
);
    localparam int KEEP_W = ADDR_W + DATA_W;

    logic [3:0]        lvl;
    logic [1:0]        rise;
    logic [KEEP_W-1:0] word;
    logic              word_ok;
    ctl_regs_t         regs;

    // line order: 0 serial clock, 1 latch, 2 data, 3 select
    ctl_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, cfg_dat_i, cfg_lat_i, cfg_clk_i}),
        .lvl_o   (lvl)
    );

    ctl_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl[1:0]),
        .rise_o (rise)
    );

    ctl_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (rise[0]),
        .lat_stb_i (rise[1]),
        .sdat_i    (lvl[2]),
        .word_o    (word),
        .word_ok_o (word_ok)
    );

    ctl_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (rise[1]),
        .word_ok_i (word_ok),
        .word_i    (word),
        .cs_n_i    (lvl[3]),
        .ready_i   (dev_ready_i),
        .regs_o    (regs)
    );

    always_comb begin
        att_left_o       = regs.att_l;
        att_left_load_o  = regs.ld_l;
        att_right_o      = regs.att_r;
        att_right_load_o = regs.ld_r;
        word_len_o       = regs.wlen;
        dac_force_zero_o = regs.dac_off;
        deemph_en_o      = regs.deemph;
        soft_mute_o      = regs.mute;
        zero_det_en_o    = regs.zdet;
        fs_sel_o         = regs.fs_sel;
        phase_rev_o      = regs.rev;
        slow_rolloff_o   = regs.slow;
        att_common_o     = regs.att_com;
        lr_swap_o        = regs.lrpol;
        i2s_fmt_o        = regs.i2s;
        clkdet_off_o     = regs.cdo;
        diff_mode_o      = regs.diff;
    end
endmodule

// File: tb/tb_ctl_port_top.sv
module tb_ctl_port_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_ready = 1'b1;
    logic cs_n = 1'b0;
    logic sdat = 1'b0;
    logic sclk = 1'b0;
    logic slat = 1'b0;

    logic [7:0] att_l, att_r;
    logic ld_l, ld_r, dac_off, dem, mute, zdet, rev, slow, com, lrp, i2s, cdo;
    logic [1:0] wlen, fs, diff;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] e_attl, e_attr;
    logic e_ldl, e_ldr, e_off, e_dem, e_mute, e_zd, e_rev, e_slow, e_com, e_lrp, e_i2s, e_cdo;
    logic [1:0] e_wlen, e_fs, e_diff;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_port_top dut (
        .clk(clk), .rst_n(rst_n), .dev_ready_i(dev_ready), .cs_n_i(cs_n),
        .cfg_dat_i(sdat), .cfg_clk_i(sclk), .cfg_lat_i(slat),
        .att_left_o(att_l), .att_left_load_o(ld_l),
        .att_right_o(att_r), .att_right_load_o(ld_r),
        .word_len_o(wlen), .dac_force_zero_o(dac_off), .deemph_en_o(dem),
        .soft_mute_o(mute), .zero_det_en_o(zdet), .fs_sel_o(fs),
        .phase_rev_o(rev), .slow_rolloff_o(slow), .att_common_o(com),
        .lr_swap_o(lrp), .i2s_fmt_o(i2s), .clkdet_off_o(cdo), .diff_mode_o(diff)
    );

    function automatic logic [63:0] act_vec();
        return 64'({ld_l, att_l, ld_r, att_r, wlen, dac_off, dem, mute, zdet, fs,
                    rev, slow, com, lrp, i2s, cdo, diff});
    endfunction

    function automatic logic [63:0] exp_vec();
        return 64'({e_ldl, e_attl, e_ldr, e_attr, e_wlen, e_off, e_dem, e_mute, e_zd, e_fs,
                    e_rev, e_slow, e_com, e_lrp, e_i2s, e_cdo, e_diff});
    endfunction

    function automatic logic [15:0] mk(logic [3:0] junk, logic [2:0] a, logic [8:0] d);
        return {junk, a, d};
    endfunction

    task automatic exp_defaults();
        e_attl = 8'hFF; e_attr = 8'hFF; e_ldl = 0; e_ldr = 0;
        e_wlen = 0; e_off = 0; e_dem = 0; e_mute = 0;
        e_zd = 0; e_fs = 0; e_rev = 0; e_slow = 0; e_com = 0; e_lrp = 0; e_i2s = 0;
        e_cdo = 0; e_diff = 0;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        check(req, act_vec(), exp_vec());
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input logic sel);
        cs_n = sel;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdat = (i < 16) ? w[i] : 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        slat = 1'b1;
        repeat (HALF) @(negedge clk);
        slat = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic t_reset();
        exp_defaults();
        check_all("R7 reset defaults");
    endtask

    task automatic t_left_right();
        send(mk(4'hA, 3'b000, 9'h12A), 16, 1'b0);
        e_ldl = 1; e_attl = 8'h2A;
        check_all("R1 R2 R3 left write with junk upper bits");
        send(mk(4'h5, 3'b001, 9'h055), 16, 1'b0);
        e_ldr = 0; e_attr = 8'h55;
        check_all("R3 right write");
    endtask

    task automatic t_mode_fmt();
        send(mk(4'h0, 3'b010, 9'h01B), 16, 1'b0);
        e_wlen = 2'b11; e_off = 0; e_dem = 1; e_mute = 1;
        check_all("R4 mode register fields");
        send(mk(4'hF, 3'b011, 9'h1FF), 16, 1'b0);
        e_zd = 1; e_fs = 2'b11; e_rev = 1; e_slow = 1; e_com = 1; e_lrp = 1; e_i2s = 1;
        check_all("R5 format register all ones");
        send(mk(4'h0, 3'b011, 9'h0A4), 16, 1'b0);
        e_zd = 0; e_fs = 2'b10; e_rev = 0; e_slow = 0; e_com = 1; e_lrp = 0; e_i2s = 0;
        check_all("R5 format register bit 5 ignored");
    endtask

    task automatic t_hidden();
        send(mk(4'h0, 3'b110, 9'h070), 16, 1'b0);
        check_all("R6 hidden write while locked ignored");
        send(mk(4'h0, 3'b010, 9'h1E0), 16, 1'b0);
        e_wlen = 0; e_off = 0; e_dem = 0; e_mute = 0;
        check_all("R6 R4 key write clears mode fields");
        send(mk(4'h0, 3'b110, 9'h070), 16, 1'b0);
        e_cdo = 1; e_diff = 2'b11;
        check_all("R6 hidden write after key");
        send(mk(4'h0, 3'b110, 9'h020), 16, 1'b0);
        e_cdo = 0; e_diff = 2'b10;
        check_all("R6 unlock persists");
        send(mk(4'h0, 3'b010, 9'h0E4), 16, 1'b0);
        e_off = 1;
        check_all("R6 partial key mode write");
        send(mk(4'h0, 3'b110, 9'h050), 16, 1'b0);
        check_all("R6 relocked after keyless mode write");
    endtask

    task automatic t_gates();
        send(mk(4'h0, 3'b000, 9'h033), 16, 1'b1);
        check_all("R8 select high ignored");
        dev_ready = 1'b0;
        send(mk(4'h0, 3'b001, 9'h111), 16, 1'b0);
        check_all("R9 not ready ignored");
        dev_ready = 1'b1;
        send(mk(4'h0, 3'b001, 9'h111), 16, 1'b0);
        e_ldr = 1; e_attr = 8'h11;
        check_all("R9 ready again accepted");
    endtask

    task automatic t_undef();
        send(mk(4'h0, 3'b100, 9'h1FF), 16, 1'b0);
        send(mk(4'h0, 3'b101, 9'h000), 16, 1'b0);
        send(mk(4'h0, 3'b111, 9'h0F0), 16, 1'b0);
        check_all("R10 undefined addresses ignored");
    endtask

    task automatic t_len();
        send(mk(4'h0, 3'b000, 9'h0C3), 15, 1'b0);
        check_all("R11 fifteen bits ignored");
        send(mk(4'h0, 3'b000, 9'h0C3), 17, 1'b0);
        check_all("R11 seventeen bits ignored");
        send(mk(4'h0, 3'b000, 9'h0C3), 16, 1'b0);
        e_ldl = 0; e_attl = 8'hC3;
        check_all("R11 sixteen bits accepted after bad lengths");
    endtask

    task automatic t_rereset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        exp_defaults();
        check_all("R7 defaults after second reset");
        send(mk(4'h0, 3'b110, 9'h070), 16, 1'b0);
        check_all("R7 R6 reset relocks hidden register");
    endtask

    initial begin
        exp_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_left_right();
        t_mode_fmt();
        t_hidden();
        t_gates();
        t_undef();
        t_len();
        t_rereset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule